// File: doc/BRIEF.md
# Bus Access Match Comparator

This block sits beside a CPU bus and inspects every access. When an access carries the programmed address and also passes the optional direction, size and masked data filters, the block raises a single-cycle match pulse. A debug controller uses this pulse to start a trace or to take a breakpoint.

The bus is big-endian. On a word access, the high byte lane carries the byte at the access address and the low byte lane carries the byte at the next address. On a byte access, the byte sits in the high lane and the low lane has no defined meaning. The data filter is a plain per-bit compare under a mask, and it does not depend on the size of the access. Because of this, a byte access can match on a low-lane compare whenever the size filter is off. The block keeps that behaviour on purpose.

Top module: `bus_match_cmp`

## Requirements
- R1: `match_o` is 0 during reset and in the first cycle after reset is released.
- R2: A match requires `acc_addr` to equal `cfg_addr` exactly. A word access at `cfg_addr`-1 touches the compare address but never matches.
- R3: With `cfg_size_en`=0, both byte accesses (`acc_word`=0) and word accesses (`acc_word`=1) at the compare address can match.
- R4: With `cfg_size_en`=1 and `cfg_size_word`=1, only word accesses can match.
- R5: With `cfg_size_en`=1 and `cfg_size_word`=0, only byte accesses can match.
- R6: With `cfg_dir_en`=0, reads (`acc_rd`=1) and writes (`acc_rd`=0) match alike. With `cfg_dir_en`=1, a match needs `acc_rd` to equal `cfg_dir_rd`.
- R7: The data filter passes when, for every bit set in `cfg_mask`, the `acc_data` bit equals the `cfg_data` bit. Bits [15:8] hold the byte at the compare address and bits [7:0] hold the byte at the next address. Mask 0xFF00 checks only the compare-address byte, 0x00FF checks only the next-address byte, and 0xFFFF checks both.
- R8: A mask of 0x0000 disables the data compare, so any data passes.
- R9: A byte access with the size filter off and a mask that covers bits [7:0] is compared on its undefined low lane. It matches when that lane agrees with `cfg_data`, and the block does not suppress this match.
- R10: `match_o` rises in the cycle after a qualifying access with `acc_valid`=1 and stays high for exactly that cycle per access. An access with `acc_valid`=0 never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access address |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_data | input | DATA_W | Access data; high lane holds the byte at the access address |
| cfg_addr | input | ADDR_W | Compare address |
| cfg_dir_en | input | 1 | Enables the direction filter |
| cfg_dir_rd | input | 1 | Expected direction (1 = read) |
| cfg_size_en | input | 1 | Enables the size filter |
| cfg_size_word | input | 1 | Expected size (1 = word) |
| cfg_data | input | DATA_W | Data compare value |
| cfg_mask | input | DATA_W | Data compare mask; a set bit is compared |
| match_o | output | 1 | Registered match pulse |

## Verification
The assertions assume that the configuration inputs are stable around each access they judge. Each assertion reads the configuration and the access fields one cycle in the past, so a configuration change in the same cycle as an access would be checked against mixed values. The bench writes the configuration only between accesses, with `acc_valid` low. It drives every access for a single cycle at the falling edge, so each check compares one access against one configuration. Random accesses are steered toward the compare address, the address just below it, and data near the compare value, so that the filters are exercised at their edges and not only on plain misses.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int LANE_W = 8;

  function automatic int lane_count(input int data_w);
    return data_w / LANE_W;
  endfunction
endpackage

// File: rtl/bmc_access_qual.sv
module bmc_access_qual #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_dir_en,
  input  logic              cfg_dir_rd,
  input  logic              cfg_size_en,
  input  logic              cfg_size_word,
  output logic              qual_ok
);
  logic addr_hit;
  logic dir_ok;
  logic size_ok;

  // exact start address only: a word starting one below is not a hit
  always_comb begin
    addr_hit = (acc_addr == cfg_addr);
    dir_ok   = !cfg_dir_en || (acc_rd == cfg_dir_rd);
    size_ok  = !cfg_size_en || (acc_word == cfg_size_word);
    qual_ok  = addr_hit && dir_ok && size_ok;
  end
endmodule

// File: rtl/bmc_data_qual.sv
module bmc_data_qual
  import bmc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_data,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_mask,
  output logic              data_ok
);
  localparam int LANES = lane_count(DATA_W);

  logic [LANES-1:0] lane_ok;

  // per-lane masked compare; lane LANES-1 is the lowest address (big-endian)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] diff;
    always_comb begin
      diff       = (acc_data[l*LANE_W +: LANE_W] ^ cfg_data[l*LANE_W +: LANE_W])
                 & cfg_mask[l*LANE_W +: LANE_W];
      lane_ok[l] = (diff == '0);
    end
  end

  assign data_ok = &lane_ok;
endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_word,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_dir_en,
  input  logic              cfg_dir_rd,
  input  logic              cfg_size_en,
  input  logic              cfg_size_word,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_mask,
  output logic              match_o
);
  logic qual_ok;
  logic data_ok;
  logic match_q;

  bmc_access_qual #(.ADDR_W(ADDR_W)) u_acc (
    .acc_addr     (acc_addr),
    .acc_rd       (acc_rd),
    .acc_word     (acc_word),
    .cfg_addr     (cfg_addr),
    .cfg_dir_en   (cfg_dir_en),
    .cfg_dir_rd   (cfg_dir_rd),
    .cfg_size_en  (cfg_size_en),
    .cfg_size_word(cfg_size_word),
    .qual_ok      (qual_ok)
  );

  bmc_data_qual #(.DATA_W(DATA_W)) u_data (
    .acc_data(acc_data),
    .cfg_data(cfg_data),
    .cfg_mask(cfg_mask),
    .data_ok (data_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= acc_valid && qual_ok && data_ok;
  end

  assign match_o = match_q;

  // R1: cleared by reset
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !match_o);

  // R10: a pulse only follows a valid access
  assert_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(acc_valid));

  // R2: exact address
  assert_exact_addr_R2: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(acc_addr == cfg_addr));

  // R4 R5: size filter honoured
  assert_size_filter_R4: assert property (@(posedge clk) disable iff (rst)
    (match_o && $past(cfg_size_en)) |-> $past(acc_word == cfg_size_word));

  // R6: direction filter honoured
  assert_dir_filter_R6: assert property (@(posedge clk) disable iff (rst)
    (match_o && $past(cfg_dir_en)) |-> $past(acc_rd == cfg_dir_rd));

  // R7: masked data agrees
  assert_data_mask_R7: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(((acc_data ^ cfg_data) & cfg_mask) == '0));
endmodule

// File: tb/bus_match_cmp_tb.sv
module bus_match_cmp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_rd = 1'b0;
  logic        acc_word = 1'b0;
  logic [15:0] acc_data = '0;
  logic [15:0] cfg_addr = '0;
  logic        cfg_dir_en = 1'b0;
  logic        cfg_dir_rd = 1'b0;
  logic        cfg_size_en = 1'b0;
  logic        cfg_size_word = 1'b0;
  logic [15:0] cfg_data = '0;
  logic [15:0] cfg_mask = '0;
  logic        match_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_match_cmp u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_rd(acc_rd), .acc_word(acc_word), .acc_data(acc_data),
    .cfg_addr(cfg_addr), .cfg_dir_en(cfg_dir_en), .cfg_dir_rd(cfg_dir_rd),
    .cfg_size_en(cfg_size_en), .cfg_size_word(cfg_size_word),
    .cfg_data(cfg_data), .cfg_mask(cfg_mask), .match_o(match_o)
  );

  function automatic bit model(input bit v, input logic [15:0] a, input bit rd,
                               input bit wd, input logic [15:0] d);
    bit ok;
    ok = v && (a == cfg_addr);
    if (cfg_dir_en && (rd != cfg_dir_rd)) ok = 0;
    if (cfg_size_en && (wd != cfg_size_word)) ok = 0;
    for (int b = 0; b < 16; b++)
      if (cfg_mask[b] && (d[b] != cfg_data[b])) ok = 0;
    return ok;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: match_o=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [15:0] a, input bit de, input bit dr,
                     input bit se, input bit sw, input logic [15:0] d,
                     input logic [15:0] m);
    @(negedge clk);
    acc_valid = 0;
    cfg_addr = a; cfg_dir_en = de; cfg_dir_rd = dr;
    cfg_size_en = se; cfg_size_word = sw; cfg_data = d; cfg_mask = m;
  endtask

  // drive one access for one cycle, check the registered result one cycle later
  task automatic acc(input string tag, input bit v, input logic [15:0] a,
                     input bit rd, input bit wd, input logic [15:0] d,
                     input bit exp);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_rd = rd; acc_word = wd; acc_data = d;
    @(negedge clk);
    acc_valid = 0;
    check(tag, match_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    acc_valid = 1; acc_addr = 16'h0000;  // would match default cfg
    repeat (3) @(negedge clk);
    check("R1 in reset", match_o, 0);
    rst = 0;
    acc_valid = 0;
    @(negedge clk);
    check("R1 after reset", match_o, 0);

    // R2 exact address
    cfg(16'h4010, 0, 0, 0, 0, 16'h0000, 16'h0000);
    acc("R2 exact word", 1, 16'h4010, 1, 1, 16'h1234, 1);
    acc("R2 word at addr-1", 1, 16'h400F, 1, 1, 16'h1234, 0);
    acc("R2 addr+1", 1, 16'h4011, 0, 0, 16'h1234, 0);
    // R3 size filter off
    acc("R3 byte", 1, 16'h4010, 0, 0, 16'h5500, 1);
    acc("R3 word", 1, 16'h4010, 0, 1, 16'h5566, 1);
    // R4 word only
    cfg(16'h4010, 0, 0, 1, 1, 16'h0000, 16'h0000);
    acc("R4 word", 1, 16'h4010, 0, 1, 16'h0000, 1);
    acc("R4 byte rejected", 1, 16'h4010, 0, 0, 16'h0000, 0);
    // R5 byte only
    cfg(16'h4010, 0, 0, 1, 0, 16'h0000, 16'h0000);
    acc("R5 byte", 1, 16'h4010, 1, 0, 16'h0000, 1);
    acc("R5 word rejected", 1, 16'h4010, 1, 1, 16'h0000, 0);
    // R6 direction
    cfg(16'h4010, 1, 1, 0, 0, 16'h0000, 16'h0000);
    acc("R6 read ok", 1, 16'h4010, 1, 1, 16'h0000, 1);
    acc("R6 write rejected", 1, 16'h4010, 0, 1, 16'h0000, 0);
    cfg(16'h4010, 1, 0, 0, 0, 16'h0000, 16'h0000);
    acc("R6 write ok", 1, 16'h4010, 0, 1, 16'h0000, 1);
    acc("R6 read rejected", 1, 16'h4010, 1, 1, 16'h0000, 0);
    cfg(16'h4010, 0, 1, 0, 0, 16'h0000, 16'h0000);
    acc("R6 filter off write", 1, 16'h4010, 0, 1, 16'h0000, 1);
    // R7 masks
    cfg(16'h4010, 0, 0, 0, 0, 16'hA55A, 16'hFF00);
    acc("R7 hi mask hit", 1, 16'h4010, 0, 1, 16'hA500, 1);
    acc("R7 hi mask miss", 1, 16'h4010, 0, 1, 16'hA45A, 0);
    cfg(16'h4010, 0, 0, 0, 0, 16'hA55A, 16'h00FF);
    acc("R7 lo mask hit", 1, 16'h4010, 0, 1, 16'h005A, 1);
    acc("R7 lo mask miss", 1, 16'h4010, 0, 1, 16'hA55B, 0);
    cfg(16'h4010, 0, 0, 0, 0, 16'hA55A, 16'hFFFF);
    acc("R7 full hit", 1, 16'h4010, 0, 1, 16'hA55A, 1);
    acc("R7 full miss", 1, 16'h4010, 0, 1, 16'h255A, 0);
    // R8 mask zero
    cfg(16'h4010, 0, 0, 0, 0, 16'hA55A, 16'h0000);
    acc("R8 any data", 1, 16'h4010, 0, 1, 16'h0F0F, 1);
    // R9 unintended byte match on low lane
    cfg(16'h4010, 0, 0, 0, 0, 16'h003C, 16'h00FF);
    acc("R9 byte low lane hit", 1, 16'h4010, 0, 0, 16'h993C, 1);
    acc("R9 byte low lane miss", 1, 16'h4010, 0, 0, 16'h993D, 0);
    // R10 timing
    cfg(16'h4010, 0, 0, 0, 0, 16'h0000, 16'h0000);
    acc("R10 invalid strobe", 0, 16'h4010, 0, 1, 16'h0000, 0);
    @(negedge clk);
    acc_valid = 1; acc_addr = 16'h4010;
    @(negedge clk);
    check("R10 first of pair", match_o, 1);
    acc_valid = 0;
    @(negedge clk);
    check("R10 pulse ends", match_o, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ca, cd, cm, a, d;
      bit v, rd, wd, e;
      ca = 16'($urandom);
      cd = 16'($urandom);
      case ($urandom % 5)
        0: cm = 16'h0000; 1: cm = 16'hFF00; 2: cm = 16'h00FF;
        3: cm = 16'hFFFF; default: cm = 16'($urandom);
      endcase
      cfg(ca, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), cd, cm);
      case ($urandom % 4)
        0, 1: a = ca; 2: a = ca - 16'd1; default: a = 16'($urandom);
      endcase
      d = cd ^ (($urandom % 2) ? 16'h0000 : (16'd1 << ($urandom % 16)));
      v = ($urandom % 8) != 0;
      rd = 1'($urandom); wd = 1'($urandom);
      e = model(v, a, rd, wd, d);
      acc("R7 random", v, a, rd, wd, d, e);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule